// File: doc/BRIEF.md
# Operand Bypass and Hazard Stall Control

This block sits at the Decode-to-Execute boundary of a four-stage in-order pipeline made of Fetch, Decode, Execute and Write stages. Each cycle it compares the source register numbers of the instruction in Decode with the destination registers of the older instructions in Execute and Write. From that comparison it decides whether the Decode instruction may go on to Execute, and where each of its two ALU operands comes from.

A build parameter picks one of two policies. With bypassing enabled, a matching operand is taken straight from the current ALU output or from the result being written back, so a dependent instruction is never held. With bypassing disabled, any dependence on an older unfinished instruction holds Fetch and Decode and sends a bubble into Execute until the producer has passed its Write step. For a back-to-back dependent pair this costs two cycles.

The block also holds the operand pair and issue-valid flag that the Execute stage consumes in the next cycle. A stalled cycle loads an empty slot there.

Top module: `opfwd_stall_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `iss_vld`, `iss_opa` and `iss_opb` are all zero.
- R2: With bypassing on, a used, non-zero source that matches the destination of a valid Execute-stage instruction gets select code 1. One cycle later the issued operand equals the `exe_alu_res` value of that cycle.
- R3: With bypassing on, a source that matches only a valid Write-stage destination gets select code 2. The issued operand equals `wrb_res`.
- R4: When both the Execute and the Write stage match a source, the Execute stage (the younger producer) wins and the select code is 1.
- R5: A source with no producer match gets select code 0. The issued operand equals the register-file read data (`rf_rd1` for A, `rf_rd2` for B).
- R6: Register 0, a producer whose valid bit is low, and a source whose use bit is low never produce a match: select 0 and no stall.
- R7: With bypassing off, select codes are always 0, and `stall` is high whenever a valid Decode instruction has a matching source in either producer stage.
- R8: With bypassing on, `stall` is never asserted.
- R9: `bubble` equals `stall`. After a stalled cycle `iss_vld` is 0. After a non-stalled cycle `iss_vld` equals the previous `dec_vld`.
- R10: For a dependent instruction that directly follows its producer, the instruction waits in Decode for exactly two stall cycles with bypassing off, and for none with bypassing on.
- R11: `stall` is low whenever `dec_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_vld | input | 1 | Decode stage holds an instruction |
| dec_use_rs1 | input | 1 | Decode instruction reads source A |
| dec_rs1 | input | RW | Source A register number |
| dec_use_rs2 | input | 1 | Decode instruction reads source B |
| dec_rs2 | input | RW | Source B register number |
| exe_vld | input | 1 | Execute stage holds a real instruction |
| exe_rd | input | RW | Execute-stage destination register |
| wrb_vld | input | 1 | Write stage holds a real instruction |
| wrb_rd | input | RW | Write-stage destination register |
| exe_alu_res | input | DW | Current ALU output |
| wrb_res | input | DW | Result being written back |
| rf_rd1 | input | DW | Register-file read data for source A |
| rf_rd2 | input | DW | Register-file read data for source B |
| sel_a | output | 2 | Source A select: 0 register file, 1 Execute, 2 Write |
| sel_b | output | 2 | Source B select, same encoding |
| stall | output | 1 | Hold Fetch and Decode this cycle |
| bubble | output | 1 | Load an empty slot into Execute |
| iss_vld | output | 1 | Execute stage input is a real instruction |
| iss_opa | output | DW | Operand A presented to Execute |
| iss_opb | output | DW | Operand B presented to Execute |

## Verification
Every cycle, the assertions check the per-cycle control relations: the younger-producer priority, the exclusion of register 0 and of idle stages, the never-stall rule under bypassing, the mandatory stall without it, and the bubble and issue-valid sequencing one cycle later. Only the bench scenarios can show the cycle cost of a dependent pair as it moves through a modelled pipeline: two held cycles without bypassing, none with it. The same holds for the correct ALU value reaching Execute for the dependent instruction.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    typedef enum logic [1:0] {
        OPSEL_RF  = 2'd0,
        OPSEL_EXE = 2'd1,
        OPSEL_WRB = 2'd2
    } opsel_e;

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match #(
    parameter int RW = 5
) (
    input  logic          use_src,
    input  logic [RW-1:0] src,
    input  logic          exe_vld,
    input  logic [RW-1:0] exe_rd,
    input  logic          wrb_vld,
    input  logic [RW-1:0] wrb_rd,
    output logic          hit_exe,
    output logic          hit_wrb
);

    logic live;

    // Register 0 is never a real destination; unused sources never compare.
    always_comb begin
        live    = use_src && (src != '0);
        hit_exe = live && exe_vld && (exe_rd == src);
        hit_wrb = live && wrb_vld && (wrb_rd == src);
    end

endmodule

// File: rtl/opfwd_policy.sv
module opfwd_policy #(
    parameter int FWD_EN = 1
) (
    input  logic                hit_exe,
    input  logic                hit_wrb,
    output opfwd_pkg::opsel_e   sel,
    output logic                hazard
);

    import opfwd_pkg::*;

    generate
        if (FWD_EN != 0) begin : g_bypass
            // Youngest producer first.
            always_comb begin
                hazard = 1'b0;
                if (hit_exe)      sel = OPSEL_EXE;
                else if (hit_wrb) sel = OPSEL_WRB;
                else              sel = OPSEL_RF;
            end
        end else begin : g_interlock
            always_comb begin
                sel    = OPSEL_RF;
                hazard = hit_exe || hit_wrb;
            end
        end
    endgenerate

endmodule

// File: rtl/opfwd_opmux.sv
module opfwd_opmux #(
    parameter int DW = 32
) (
    input  opfwd_pkg::opsel_e sel,
    input  logic [DW-1:0]     rf_val,
    input  logic [DW-1:0]     exe_val,
    input  logic [DW-1:0]     wrb_val,
    output logic [DW-1:0]     val
);

    import opfwd_pkg::*;

    always_comb begin
        case (sel)
            OPSEL_EXE: val = exe_val;
            OPSEL_WRB: val = wrb_val;
            default:   val = rf_val;
        endcase
    end

endmodule

// File: rtl/opfwd_stall_unit.sv
module opfwd_stall_unit #(
    parameter int RW     = 5,
    parameter int DW     = 32,
    parameter int FWD_EN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_vld,
    input  logic          dec_use_rs1,
    input  logic [RW-1:0] dec_rs1,
    input  logic          dec_use_rs2,
    input  logic [RW-1:0] dec_rs2,
    input  logic          exe_vld,
    input  logic [RW-1:0] exe_rd,
    input  logic          wrb_vld,
    input  logic [RW-1:0] wrb_rd,
    input  logic [DW-1:0] exe_alu_res,
    input  logic [DW-1:0] wrb_res,
    input  logic [DW-1:0] rf_rd1,
    input  logic [DW-1:0] rf_rd2,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic          stall,
    output logic          bubble,
    output logic          iss_vld,
    output logic [DW-1:0] iss_opa,
    output logic [DW-1:0] iss_opb
);

    import opfwd_pkg::*;

    localparam int NSRC = 2;

    logic [NSRC-1:0] use_v;
    logic [RW-1:0]   src_v [NSRC];
    logic [DW-1:0]   rf_v  [NSRC];
    logic [DW-1:0]   val_v [NSRC];
    opsel_e          sel_v [NSRC];
    logic [NSRC-1:0] hex_v;
    logic [NSRC-1:0] hwb_v;
    logic [NSRC-1:0] hzd_v;

    always_comb begin
        use_v[0] = dec_use_rs1;
        use_v[1] = dec_use_rs2;
        src_v[0] = dec_rs1;
        src_v[1] = dec_rs2;
        rf_v[0]  = rf_rd1;
        rf_v[1]  = rf_rd2;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            opfwd_match #(.RW(RW)) u_match (
                .use_src (use_v[i]),
                .src     (src_v[i]),
                .exe_vld (exe_vld),
                .exe_rd  (exe_rd),
                .wrb_vld (wrb_vld),
                .wrb_rd  (wrb_rd),
                .hit_exe (hex_v[i]),
                .hit_wrb (hwb_v[i])
            );

            opfwd_policy #(.FWD_EN(FWD_EN)) u_policy (
                .hit_exe (hex_v[i]),
                .hit_wrb (hwb_v[i]),
                .sel     (sel_v[i]),
                .hazard  (hzd_v[i])
            );

            opfwd_opmux #(.DW(DW)) u_mux (
                .sel     (sel_v[i]),
                .rf_val  (rf_v[i]),
                .exe_val (exe_alu_res),
                .wrb_val (wrb_res),
                .val     (val_v[i])
            );
        end
    endgenerate

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
    } iss_t;

    iss_t iss_d;
    iss_t iss_q;
    logic hold_d;

    always_comb begin
        hold_d    = dec_vld && (|hzd_v);
        iss_d     = iss_q;
        iss_d.vld = dec_vld && !hold_d;
        if (!hold_d) begin
            iss_d.opa = val_v[0];
            iss_d.opb = val_v[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign sel_a   = sel_v[0];
    assign sel_b   = sel_v[1];
    assign stall   = hold_d;
    assign bubble  = hold_d;
    assign iss_vld = iss_q.vld;
    assign iss_opa = iss_q.opa;
    assign iss_opb = iss_q.opb;

endmodule

// File: rtl/opfwd_stall_unit_chk.sv
module opfwd_stall_unit_chk #(
    parameter int RW     = 5,
    parameter int DW     = 32,
    parameter int FWD_EN = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_vld,
    input logic          dec_use_rs1,
    input logic [RW-1:0] dec_rs1,
    input logic          exe_vld,
    input logic [RW-1:0] exe_rd,
    input logic          wrb_vld,
    input logic [RW-1:0] wrb_rd,
    input logic [DW-1:0] exe_alu_res,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic          stall,
    input logic          bubble,
    input logic          iss_vld,
    input logic [DW-1:0] iss_opa
);

    localparam logic BYP = (FWD_EN != 0);

    logic a_live;
    logic a_exe;
    logic a_wrb;
    assign a_live = dec_use_rs1 && (dec_rs1 != '0);
    assign a_exe  = a_live && exe_vld && (exe_rd == dec_rs1);
    assign a_wrb  = a_live && wrb_vld && (wrb_rd == dec_rs1);

    // R4: younger producer wins
    p_exe_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (BYP && a_exe && a_wrb) |-> (sel_a == 2'd1));

    // R2: Execute-stage value reaches the issued operand
    p_exe_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (BYP && dec_vld && a_exe) |=> (iss_opa == $past(exe_alu_res)));

    // R6: register 0 or unused source never selects a bypass
    p_no_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_live) |-> (sel_a == 2'd0));

    // R7: interlock mode never bypasses and always holds on a match
    p_interlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!BYP) |-> (sel_a == 2'd0 && sel_b == 2'd0));

    p_interlock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!BYP && dec_vld && (a_exe || a_wrb)) |-> stall);

    // R8: bypass mode never holds
    p_never_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        BYP |-> !stall);

    // R9: bubble follows a hold, issue follows decode otherwise
    p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !iss_vld);

    p_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (iss_vld == $past(dec_vld)));

    p_bubble_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bubble == stall);

    // R11: an empty Decode stage never holds
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> !stall);

endmodule

bind opfwd_stall_unit opfwd_stall_unit_chk #(
    .RW(RW), .DW(DW), .FWD_EN(FWD_EN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_vld     (dec_vld),
    .dec_use_rs1 (dec_use_rs1),
    .dec_rs1     (dec_rs1),
    .exe_vld     (exe_vld),
    .exe_rd      (exe_rd),
    .wrb_vld     (wrb_vld),
    .wrb_rd      (wrb_rd),
    .exe_alu_res (exe_alu_res),
    .sel_a       (sel_a),
    .sel_b       (sel_b),
    .stall       (stall),
    .bubble      (bubble),
    .iss_vld     (iss_vld),
    .iss_opa     (iss_opa)
);

// File: tb/opfwd_stall_unit_tb.sv
module opfwd_stall_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // lane 0: bypassing on, lane 1: bypassing off
    logic          d_vld [2];
    logic          d_u1  [2];
    logic [RW-1:0] d_s1  [2];
    logic          d_u2  [2];
    logic [RW-1:0] d_s2  [2];
    logic          e_vld [2];
    logic [RW-1:0] e_rd  [2];
    logic          w_vld [2];
    logic [RW-1:0] w_rd  [2];
    logic [DW-1:0] e_res [2];
    logic [DW-1:0] w_res [2];
    logic [DW-1:0] rf1   [2];
    logic [DW-1:0] rf2   [2];
    logic [1:0]    o_sa  [2];
    logic [1:0]    o_sb  [2];
    logic          o_st  [2];
    logic          o_bb  [2];
    logic          o_iv  [2];
    logic [DW-1:0] o_oa  [2];
    logic [DW-1:0] o_ob  [2];

    int checks = 0;
    int fails  = 0;

    opfwd_stall_unit #(.RW(RW), .DW(DW), .FWD_EN(1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dec_vld(d_vld[0]), .dec_use_rs1(d_u1[0]), .dec_rs1(d_s1[0]),
        .dec_use_rs2(d_u2[0]), .dec_rs2(d_s2[0]),
        .exe_vld(e_vld[0]), .exe_rd(e_rd[0]), .wrb_vld(w_vld[0]), .wrb_rd(w_rd[0]),
        .exe_alu_res(e_res[0]), .wrb_res(w_res[0]), .rf_rd1(rf1[0]), .rf_rd2(rf2[0]),
        .sel_a(o_sa[0]), .sel_b(o_sb[0]), .stall(o_st[0]), .bubble(o_bb[0]),
        .iss_vld(o_iv[0]), .iss_opa(o_oa[0]), .iss_opb(o_ob[0])
    );

    opfwd_stall_unit #(.RW(RW), .DW(DW), .FWD_EN(0)) u_dut_nf (
        .clk(clk), .rst_n(rst_n),
        .dec_vld(d_vld[1]), .dec_use_rs1(d_u1[1]), .dec_rs1(d_s1[1]),
        .dec_use_rs2(d_u2[1]), .dec_rs2(d_s2[1]),
        .exe_vld(e_vld[1]), .exe_rd(e_rd[1]), .wrb_vld(w_vld[1]), .wrb_rd(w_rd[1]),
        .exe_alu_res(e_res[1]), .wrb_res(w_res[1]), .rf_rd1(rf1[1]), .rf_rd2(rf2[1]),
        .sel_a(o_sa[1]), .sel_b(o_sb[1]), .stall(o_st[1]), .bubble(o_bb[1]),
        .iss_vld(o_iv[1]), .iss_opa(o_oa[1]), .iss_opb(o_ob[1])
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // same stage picture on both lanes
    task automatic drive(input logic dv, input logic u1, input int s1, input logic u2, input int s2,
                         input logic ev, input int er, input logic wv, input int wr);
        for (int k = 0; k < 2; k++) begin
            d_vld[k] = dv; d_u1[k] = u1; d_s1[k] = RW'(s1); d_u2[k] = u2; d_s2[k] = RW'(s2);
            e_vld[k] = ev; e_rd[k] = RW'(er); w_vld[k] = wv; w_rd[k] = RW'(wr);
            e_res[k] = 32'd1111; w_res[k] = 32'd2222; rf1[k] = 32'd31; rf2[k] = 32'd32;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        drive(1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
        rst_n = 1'b0;
        step();
        chk("R1 iss_vld in reset", {31'd0, o_iv[0]}, 0);
        chk("R1 iss_opa in reset", o_oa[0], 0);
        chk("R1 iss_opb in reset", o_ob[1], 0);
        rst_n = 1'b1;
        step();
        chk("R1 iss_vld after reset", {31'd0, o_iv[1]}, 0);
    endtask

    task automatic t_independent();
        drive(1'b1, 1'b1, 3, 1'b1, 5, 1'b1, 7, 1'b1, 9);
        #1;
        chk("R5 sel_a no match", {30'd0, o_sa[0]}, 0);
        chk("R5 sel_b no match", {30'd0, o_sb[0]}, 0);
        chk("R7 no hold when independent", {31'd0, o_st[1]}, 0);
        step();
        chk("R5 opa from register file", o_oa[0], 31);
        chk("R5 opb from register file", o_ob[1], 32);
        chk("R9 issue follows decode", {31'd0, o_iv[1]}, 1);
    endtask

    task automatic t_exe_match();
        drive(1'b1, 1'b1, 4, 1'b1, 5, 1'b1, 4, 1'b1, 9);
        #1;
        chk("R2 sel_a from execute", {30'd0, o_sa[0]}, 1);
        chk("R8 no hold with bypass", {31'd0, o_st[0]}, 0);
        chk("R7 hold on execute match", {31'd0, o_st[1]}, 1);
        chk("R9 bubble with hold", {31'd0, o_bb[1]}, 1);
        chk("R7 sel_a stays regfile", {30'd0, o_sa[1]}, 0);
        step();
        chk("R2 opa equals ALU result", o_oa[0], 1111);
        chk("R9 bubble issued after hold", {31'd0, o_iv[1]}, 0);
    endtask

    task automatic t_wrb_match();
        drive(1'b1, 1'b1, 3, 1'b1, 6, 1'b1, 7, 1'b1, 6);
        #1;
        chk("R3 sel_b from write", {30'd0, o_sb[0]}, 2);
        chk("R7 hold on write match", {31'd0, o_st[1]}, 1);
        step();
        chk("R3 opb equals write result", o_ob[0], 2222);
    endtask

    task automatic t_both_match();
        drive(1'b1, 1'b1, 8, 1'b1, 8, 1'b1, 8, 1'b1, 8);
        #1;
        chk("R4 sel_a younger wins", {30'd0, o_sa[0]}, 1);
        chk("R4 sel_b younger wins", {30'd0, o_sb[0]}, 1);
        step();
        chk("R4 opa from execute", o_oa[0], 1111);
    endtask

    task automatic t_excluded();
        drive(1'b1, 1'b1, 0, 1'b0, 0, 1'b1, 0, 1'b1, 0);
        #1;
        chk("R6 register 0 ignored (sel)", {30'd0, o_sa[0]}, 0);
        chk("R6 register 0 ignored (hold)", {31'd0, o_st[1]}, 0);
        drive(1'b1, 1'b1, 10, 1'b1, 11, 1'b0, 10, 1'b0, 11);
        #1;
        chk("R6 idle producers ignored (sel)", {30'd0, o_sa[0]}, 0);
        chk("R6 idle producers ignored (hold)", {31'd0, o_st[1]}, 0);
        drive(1'b1, 1'b0, 12, 1'b0, 13, 1'b1, 12, 1'b1, 13);
        #1;
        chk("R6 unused sources ignored (sel)", {30'd0, o_sb[0]}, 0);
        chk("R6 unused sources ignored (hold)", {31'd0, o_st[1]}, 0);
        step();
        chk("R6 issued opb from register file", o_ob[0], 32);
    endtask

    task automatic t_idle_decode();
        drive(1'b0, 1'b1, 4, 1'b1, 4, 1'b1, 4, 1'b1, 4);
        #1;
        chk("R11 empty decode never holds", {31'd0, o_st[1]}, 0);
        step();
        chk("R9 empty decode issues nothing", {31'd0, o_iv[1]}, 0);
    endtask

    // I0: writes R4 from R2,R3; I1: reads R4,R6 writes R5; I2: independent
    function automatic int f_dst(input int i);
        return (i == 0) ? 4 : (i == 1) ? 5 : 9;
    endfunction
    function automatic int f_s1(input int i);
        return (i == 0) ? 2 : (i == 1) ? 4 : 1;
    endfunction
    function automatic int f_s2(input int i);
        return (i == 0) ? 3 : (i == 1) ? 6 : 7;
    endfunction

    task automatic t_dependent_pair();
        logic dv [2]; int di [2];
        logic ev [2]; int ei [2];
        logic wv [2]; int wi [2];
        int fp [2]; int sc [2];
        logic pend [2];
        logic s;
        for (int k = 0; k < 2; k++) begin
            dv[k] = 1'b0; di[k] = 0; ev[k] = 1'b0; ei[k] = 0; wv[k] = 1'b0; wi[k] = 0;
            fp[k] = 0; sc[k] = 0; pend[k] = 1'b0;
        end
        for (int c = 0; c < 12; c++) begin
            for (int k = 0; k < 2; k++) begin
                if (pend[k]) begin
                    chk("R10 dependent operand value at issue", o_oa[k], 100);
                    pend[k] = 1'b0;
                end
                d_vld[k] = dv[k]; d_u1[k] = 1'b1; d_s1[k] = RW'(f_s1(di[k]));
                d_u2[k] = 1'b1; d_s2[k] = RW'(f_s2(di[k]));
                e_vld[k] = ev[k]; e_rd[k] = RW'(f_dst(ei[k]));
                w_vld[k] = wv[k]; w_rd[k] = RW'(f_dst(wi[k]));
                e_res[k] = 32'(100 + ei[k]); w_res[k] = 32'(200 + wi[k]);
                // register file already holds the write-back value once written
                rf1[k] = (di[k] == 1) ? 32'd100 : 32'd7;
                rf2[k] = 32'd7;
            end
            #1;
            for (int k = 0; k < 2; k++) begin
                s = o_st[k];
                if (s && dv[k] && di[k] == 1) sc[k]++;
                if (!s && dv[k] && di[k] == 1) pend[k] = 1'b1;
                wv[k] = ev[k]; wi[k] = ei[k];
                if (s) begin
                    ev[k] = 1'b0;
                end else begin
                    ev[k] = dv[k]; ei[k] = di[k];
                    if (fp[k] < 3) begin dv[k] = 1'b1; di[k] = fp[k]; fp[k]++; end
                    else dv[k] = 1'b0;
                end
            end
            step();
        end
        chk("R10 bypass lane stall cycles", 32'(sc[0]), 0);
        chk("R10 interlock lane stall cycles", 32'(sc[1]), 2);
    endtask

    initial begin
        t_reset();
        t_independent();
        t_exe_match();
        t_wrb_match();
        t_both_match();
        t_excluded();
        t_idle_decode();
        t_dependent_pair();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule